// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a two-wire bus target that holds a small bank of byte-wide control and status registers for a clock fan-out device. A host reaches the bank with indexed block transfers. A write names a starting index and a byte count, and then delivers that many data bytes to consecutive registers. A read names a starting index, issues a repeated START with the read address, and receives the readback-length register first, followed by data bytes from the starting index until the host refuses a byte with NACK.

The bus lines reach the block already synchronised to `clk`. SDA is split into an observed level (`sda_i`) and a pull-low enable (`sda_pull_low`), which drives the open-drain pad. Two three-level strap inputs are already decoded into 2-bit codes: 00 is low, 01 is mid, and 10 or 11 is high. Together they pick one of nine target addresses. The register contents come out as plain level outputs. No data stream crosses the block edge, so there is no valid/ready interface. The block never stretches SCL, so it applies no back-pressure: every byte is taken or supplied at the host's pace.

Top module: `smb_regbank_target`

## Requirements
- R1: The strap pair (hi strap, lo strap) selects the 8-bit write address. With the hi strap low: D8h, DAh, DEh for the lo strap low, mid, high. With the hi strap mid: C2h, C4h, C6h. With the hi strap high: CAh, CCh, CEh. The block ACKs only that address. Any other address is NACKed and the rest of the transfer is ignored.
- R2: The read address is the write address with bit 0 set. It is ACKed.
- R3: A write runs: address+W, index N, count X, then data. Each of these bytes is ACKed. Data byte k lands in index N+k, and registers change only on an SCL rising edge.
- R4: Data bytes after the X-th in a write are NACKed and change no register.
- R5: A read returns the readback-length register (index 7) first, then the bytes at N, N+1, … for as long as the host ACKs. After a host NACK, the block sends nothing more.
- R6: After reset, all output enables are 1, the readback length is 8, and the software-control bit and the mode field are 0.
- R7: Index 1 bits 7:0 drive enables 7..0. Index 2 bits 3:0 drive enables 11..8, and bits 7:4 read 0. In index 0, bit 3 is the software-control enable and bits 2:1 are the mode field. Index 7 bits 4:0 are the readback length, and bits 7:5 read 0.
- R8: Index 5 reads 11h and index 6 reads C9h. Index 0 bits 7:6 mirror the latched mode input, bits 5:4 read 0, and bit 0 mirrors the latched frequency input.
- R9: Writes to read-only or reserved bits (indexes 3, 4, 5, 6, 8 and all reserved fields) are ACKed and discarded. A read at an index above 8 returns 00h.
- R10: The index advances after every written or read data byte, wrapping from 8, or from any higher index, to 0.
- R11: A START or STOP inside a byte abandons the transfer without changing any register. A STOP releases SDA on the next cycle.
- R12: The block changes `sda_pull_low` only while SCL is low. It pulls SDA only for its own ACK and for 0 bits it transmits, and it releases SDA during the host's ACK bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_pull_low | output | 1 | 1 pulls the SDA pad low |
| strap_hi | input | 2 | Decoded upper address strap (00 low, 01 mid, 1x high) |
| strap_lo | input | 2 | Decoded lower address strap |
| pll_mode_latch | input | 2 | Latched mode, reported in index 0 bits 7:6 |
| freq_sel_latch | input | 1 | Latched frequency select, reported in index 0 bit 0 |
| out_en | output | 12 | Per-output enables |
| sw_ctrl_en | output | 1 | Software-control enable (index 0 bit 3) |
| sw_mode | output | 2 | Software mode field (index 0 bits 2:1) |
| rd_count | output | 5 | Readback length (index 7 bits 4:0) |

## Verification
The address decoder is tried against all nine strap settings. Each setting gets a matching probe, a foreign address and a read-address probe, which separates a wrong table entry from a missing R/W bit. Writes are tried with a count matching the payload, with excess bytes, at read-only and reserved indexes, and across the 8-to-0 wrap. This separates a wrong write mask, a wrong count limit and a wrong wrap point. Reads start inside the bank, above it, and after the length register has been rewritten, so the leading length byte, the out-of-range zero value and the increment are each visible on their own. Transfers cut by a STOP or a repeated START mid-byte show whether partial bytes leak into the bank.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA
  } phase_t;

  // Decoded strap codes: 00 low, 01 mid, 1x high.
  function automatic logic [6:0] strap_addr(input logic [1:0] hi, input logic [1:0] lo);
    logic [7:0] wa;
    unique case (hi)
      2'b00:   wa = (lo == 2'b00) ? 8'hD8 : (lo == 2'b01) ? 8'hDA : 8'hDE;
      2'b01:   wa = (lo == 2'b00) ? 8'hC2 : (lo == 2'b01) ? 8'hC4 : 8'hC6;
      default: wa = (lo == 2'b00) ? 8'hCA : (lo == 2'b01) ? 8'hCC : 8'hCE;
    endcase
    return wa[7:1];
  endfunction

endpackage

// File: rtl/smbt_line_events.sv
module smbt_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smbt_sequencer.sv
module smbt_sequencer #(
  parameter int NREG = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_bit,
  input  logic [6:0] my_addr,
  input  logic [7:0] len_byte,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_pull_low
);
  import smbt_pkg::*;

  localparam logic [7:0] LAST_IDX = 8'(NREG - 1);

  phase_t     st;
  logic [3:0] bitcnt;
  logic [6:0] shin;
  logic [7:0] txsh, idx, remain;
  logic       ack_drive, host_turn, pull;
  logic [7:0] byte_in;
  logic [7:0] idx_nx;

  assign byte_in = {shin, sda_bit};
  assign idx_nx  = (idx >= LAST_IDX) ? 8'd0 : idx + 8'd1;

  assign wr_en   = scl_rise && (st == PH_WDATA) && (bitcnt == 4'd7) && (remain != 8'd0);
  assign wr_idx  = idx;
  assign wr_data = byte_in;
  assign rd_idx  = idx;
  assign sda_pull_low = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      bitcnt    <= '0;
      shin      <= '0;
      txsh      <= '0;
      idx       <= '0;
      remain    <= '0;
      ack_drive <= 1'b0;
      host_turn <= 1'b0;
      pull      <= 1'b0;
    end else if (start_ev || stop_ev) begin
      st        <= start_ev ? PH_ADDR : PH_IDLE;
      bitcnt    <= '0;
      ack_drive <= 1'b0;
      host_turn <= 1'b0;
      pull      <= 1'b0;
    end else if (st != PH_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shin   <= byte_in[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            ack_drive <= 1'b0;
            host_turn <= 1'b0;
            unique case (st)
              PH_ADDR: begin
                if (byte_in[7:1] == my_addr) begin
                  ack_drive <= 1'b1;
                  if (byte_in[0]) begin
                    st   <= PH_RDATA;
                    txsh <= len_byte;
                  end else begin
                    st <= PH_INDEX;
                  end
                end else begin
                  st <= PH_IDLE;
                end
              end
              PH_INDEX: begin
                idx       <= byte_in;
                ack_drive <= 1'b1;
                st        <= PH_COUNT;
              end
              PH_COUNT: begin
                remain    <= byte_in;
                ack_drive <= 1'b1;
                st        <= PH_WDATA;
              end
              PH_WDATA: begin
                if (remain != 8'd0) begin
                  ack_drive <= 1'b1;
                  remain    <= remain - 8'd1;
                  idx       <= idx_nx;
                end
              end
              PH_RDATA: host_turn <= 1'b1;
              default: ;
            endcase
          end
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (host_turn) begin
            if (sda_bit) begin
              st <= PH_IDLE;
            end else begin
              txsh <= rd_data;
              idx  <= idx_nx;
            end
          end
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          pull <= ack_drive;
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          pull   <= (st == PH_RDATA) ? ~txsh[7] : 1'b0;
        end else if (st == PH_RDATA) begin
          pull <= ~txsh[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end
endmodule

// File: rtl/smbt_regbank.sv
module smbt_regbank #(
  parameter int         NOUT      = 12,
  parameter int         LEN_W     = 5,
  parameter logic [4:0] LEN_RESET = 5'd8,
  parameter logic [7:0] ID_BYTE   = 8'h11,
  parameter logic [7:0] DEV_BYTE  = 8'hC9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_idx,
  output logic [7:0]       rd_data,
  input  logic [1:0]       pll_mode_latch,
  input  logic             freq_sel_latch,
  output logic [NOUT-1:0]  out_en,
  output logic             sw_ctrl_en,
  output logic [1:0]       sw_mode,
  output logic [LEN_W-1:0] rd_count
);
  localparam int         EN_BYTES = (NOUT + 7) / 8;
  localparam int         EN_BITS  = EN_BYTES * 8;
  localparam logic [7:0] IDX_CTL  = 8'd0;
  localparam logic [7:0] IDX_ID   = 8'd5;
  localparam logic [7:0] IDX_DEV  = 8'd6;
  localparam logic [7:0] IDX_LEN  = 8'd7;

  logic [EN_BITS-1:0] en_ext;
  logic [7:0]         ctl_byte;

  for (genvar g = 0; g < NOUT; g++) begin : g_en
    localparam logic [7:0] BYTE_IDX = 8'(1 + g / 8);
    localparam int         BIT_POS  = g % 8;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            out_en[g] <= 1'b1;
      else if (wr_en && wr_idx == BYTE_IDX)  out_en[g] <= wr_data[BIT_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_ctrl_en <= 1'b0;
      sw_mode    <= 2'b00;
      rd_count   <= LEN_W'(LEN_RESET);
    end else if (wr_en) begin
      if (wr_idx == IDX_CTL) begin
        sw_ctrl_en <= wr_data[3];
        sw_mode    <= wr_data[2:1];
      end
      if (wr_idx == IDX_LEN) rd_count <= wr_data[LEN_W-1:0];
    end
  end

  assign en_ext   = EN_BITS'(out_en);
  assign ctl_byte = {pll_mode_latch, 2'b00, sw_ctrl_en, sw_mode, freq_sel_latch};

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx == IDX_CTL) rd_data = ctl_byte;
    if (rd_idx == IDX_ID)  rd_data = ID_BYTE;
    if (rd_idx == IDX_DEV) rd_data = DEV_BYTE;
    if (rd_idx == IDX_LEN) rd_data = 8'(rd_count);
    for (int b = 0; b < EN_BYTES; b++)
      if (rd_idx == 8'(1 + b)) rd_data = en_ext[8*b +: 8];
  end
endmodule

// File: rtl/smb_regbank_target.sv
module smb_regbank_target #(
  parameter int NOUT = 12,
  parameter int NREG = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_low,
  input  logic [1:0]      strap_hi,
  input  logic [1:0]      strap_lo,
  input  logic [1:0]      pll_mode_latch,
  input  logic            freq_sel_latch,
  output logic [NOUT-1:0] out_en,
  output logic            sw_ctrl_en,
  output logic [1:0]      sw_mode,
  output logic [4:0]      rd_count
);
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0] my_addr;
  logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
  logic       wr_en;

  assign my_addr = smbt_pkg::strap_addr(strap_hi, strap_lo);

  smbt_line_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smbt_sequencer #(.NREG(NREG)) u_seq (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(sda_i), .my_addr(my_addr),
    .len_byte({3'b000, rd_count}), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_pull_low(sda_pull_low)
  );

  smbt_regbank #(.NOUT(NOUT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .pll_mode_latch(pll_mode_latch),
    .freq_sel_latch(freq_sel_latch), .out_en(out_en), .sw_ctrl_en(sw_ctrl_en),
    .sw_mode(sw_mode), .rd_count(rd_count)
  );
endmodule

// File: rtl/smbt_checker.sv
module smbt_checker #(
  parameter int NOUT = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            sda_i,
  input logic            sda_pull_low,
  input logic [NOUT-1:0] out_en,
  input logic            sw_ctrl_en,
  input logic [1:0]      sw_mode,
  input logic [4:0]      rd_count
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&out_en && rd_count == 5'd8 && !sw_ctrl_en && sw_mode == 2'b00)); // R6

  AST_REGS_ON_SCL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_i && !$past(scl_i)) |=> $stable({out_en, sw_ctrl_en, sw_mode, rd_count})); // R3

  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> !scl_i); // R12

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull_low); // R11
endmodule

bind smb_regbank_target smbt_checker #(.NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_pull_low(sda_pull_low),
  .out_en(out_en), .sw_ctrl_en(sw_ctrl_en), .sw_mode(sw_mode), .rd_count(rd_count)
);

// File: tb/sim_smb_regbank_target.sv
module sim_smb_regbank_target;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic [1:0] strap_hi = 2'b00, strap_lo = 2'b00, pll_mode_latch = 2'b10;
  logic freq_sel_latch = 1'b1;
  wire  sda_pull_low;
  wire  sda_line = sda_h & ~sda_pull_low;
  wire [11:0] out_en;
  wire sw_ctrl_en;
  wire [1:0] sw_mode;
  wire [4:0] rd_count;

  always #4 clk = ~clk;

  smb_regbank_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_pull_low(sda_pull_low),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .pll_mode_latch(pll_mode_latch),
    .freq_sel_latch(freq_sel_latch), .out_en(out_en), .sw_ctrl_en(sw_ctrl_en),
    .sw_mode(sw_mode), .rd_count(rd_count)
  );

  int checks = 0, fails = 0;
  bit settle = 1'b1, done = 1'b0;

  // behavioural model of the bank
  logic [11:0] m_en = 12'hFFF;
  logic [2:0]  m_ctl = 3'b000;   // {sw_ctrl, mode[1:0]}
  logic [4:0]  m_len = 5'd8;

  function automatic logic [7:0] m_read(input int i);
    case (i)
      0: return {pll_mode_latch, 2'b00, m_ctl, freq_sel_latch};
      1: return m_en[7:0];
      2: return {4'h0, m_en[11:8]};
      5: return 8'h11;
      6: return 8'hC9;
      7: return {3'b000, m_len};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void m_write(input int i, input logic [7:0] d);
    case (i)
      0: m_ctl = d[3:1];
      1: m_en[7:0] = d;
      2: m_en[11:8] = d[3:0];
      7: m_len = d[4:0];
      default: ;
    endcase
  endfunction

  function automatic int nxt(input int i);
    return (i >= 8) ? 0 : i + 1;
  endfunction

  function automatic logic [7:0] addr_of(input logic [1:0] h, input logic [1:0] l);
    logic [7:0] t [0:8];
    t = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4, 8'hC6, 8'hCA, 8'hCC, 8'hCE};
    return t[(h > 2 ? 2 : h) * 3 + (l > 2 ? 2 : l)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !settle && !done) begin
      chk(out_en == m_en, "R7 out_en", out_en, m_en);
      chk({sw_ctrl_en, sw_mode} == m_ctl, "R7 ctl", {sw_ctrl_en, sw_mode}, m_ctl);
      chk(rd_count == m_len, "R7 len", rd_count, m_len);
    end
  end

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b);
    sda_h = b; wc(Q); scl_h = 1'b1; wc(Q); scl_h = 1'b0; wc(1);
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; wc(Q); scl_h = 1'b1; wc(Q/2); b = sda_line; wc(Q/2); scl_h = 1'b0; wc(1);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wc(Q); scl_h = 1'b1; wc(Q); sda_h = 1'b0; wc(Q); scl_h = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wc(Q); scl_h = 1'b1; wc(Q); sda_h = 1'b1; wc(Q);
    chk(sda_pull_low == 1'b0, "R11 released after STOP", sda_pull_low, 0);
  endtask

  // sends a byte; on do_wr the model takes it at the byte's last SCL rise
  task automatic send_byte(input logic [7:0] b, input bit do_wr, input int widx, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wc(Q);
      if (i == 0) settle = 1'b1;
      scl_h = 1'b1; wc(2);
      if (i == 0) begin
        if (do_wr) m_write(widx, b);
        settle = 1'b0;
      end
      wc(Q - 2); scl_h = 1'b0; wc(1);
    end
    get_bit(a);
    acked = (a == 1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit host_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    sda_h = host_ack ? 1'b0 : 1'b1; wc(Q); scl_h = 1'b1; wc(Q/2);
    chk(sda_pull_low == 1'b0, "R12 released in host ACK bit", sda_pull_low, 0);
    wc(Q/2); scl_h = 1'b0; wc(1); sda_h = 1'b1;
  endtask

  task automatic blk_write(input int n, input int x, input logic [7:0] d [$]);
    bit ak; int mi;
    logic [7:0] wa;
    wa = addr_of(strap_hi, strap_lo);
    mi = n;
    bus_start();
    send_byte(wa, 0, 0, ak);       chk(ak, "R3 address ACK", ak, 1);
    send_byte(8'(n), 0, 0, ak);    chk(ak, "R3 index ACK", ak, 1);
    send_byte(8'(x), 0, 0, ak);    chk(ak, "R3 count ACK", ak, 1);
    for (int k = 0; k < d.size(); k++) begin
      send_byte(d[k], k < x, mi, ak);
      if (k < x) begin
        chk(ak, "R3 data ACK", ak, 1);
        mi = nxt(mi);
      end else begin
        chk(!ak, "R4 excess byte NACK", ak, 0);
      end
    end
    bus_stop();
  endtask

  task automatic blk_read(input int n, input int k, input string req);
    bit ak; int mi;
    logic [7:0] wa, b;
    wa = addr_of(strap_hi, strap_lo);
    mi = n;
    bus_start();
    send_byte(wa, 0, 0, ak);           chk(ak, "R5 address ACK", ak, 1);
    send_byte(8'(n), 0, 0, ak);        chk(ak, "R5 index ACK", ak, 1);
    bus_start();
    send_byte(wa | 8'h01, 0, 0, ak);   chk(ak, "R2 read address ACK", ak, 1);
    recv_byte(b, k > 0);
    chk(b == m_read(7), "R5 length byte first", b, m_read(7));
    for (int j = 0; j < k; j++) begin
      recv_byte(b, j < k - 1);
      chk(b == m_read(mi), req, b, m_read(mi));
      mi = nxt(mi);
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    bit ak;
    logic [7:0] b;
    wc(5); rst_n = 1'b1; wc(2);
    settle = 1'b0;
    chk(out_en == 12'hFFF && rd_count == 5'd8 && !sw_ctrl_en && sw_mode == 2'b00,
        "R6 reset state", {out_en, rd_count}, {12'hFFF, 5'd8});

    // R1/R2: every strap setting
    for (int h = 0; h < 3; h++) begin
      for (int l = 0; l < 3; l++) begin
        strap_hi = 2'(h); strap_lo = 2'(l); wc(2);
        bus_start(); send_byte(addr_of(strap_hi, strap_lo), 0, 0, ak); bus_stop();
        chk(ak, "R1 strap address ACK", ak, 1);
        bus_start(); send_byte(8'hA0, 0, 0, ak); bus_stop();
        chk(!ak, "R1 foreign address NACK", ak, 0);
        bus_start(); send_byte(addr_of(strap_hi, strap_lo) | 8'h01, 0, 0, ak);
        chk(ak, "R2 read address ACK", ak, 1);
        recv_byte(b, 1'b0); bus_stop();
        chk(b == m_read(7), "R2 length byte", b, m_read(7));
      end
    end
    strap_hi = 2'b11; strap_lo = 2'b01; wc(2);   // 11 decodes as high
    bus_start(); send_byte(8'hCC, 0, 0, ak); bus_stop();
    chk(ak, "R1 code 11 as high", ak, 1);

    // R3/R7: enables
    blk_write(1, 2, '{8'h5A, 8'hF3});
    blk_read(1, 2, "R7 enable readback");
    // R4: excess bytes
    blk_write(1, 1, '{8'h0F, 8'h00, 8'h77});
    blk_read(1, 2, "R4 excess not written");
    // R8/R9: read-only / reserved writes discarded
    blk_write(3, 6, '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'hE4, 8'hFF});
    blk_read(0, 9, "R8 full bank readback");
    // R10: wrap from 8
    blk_write(8, 3, '{8'hAA, 8'hFF, 8'h81});
    blk_read(7, 4, "R10 read wrap");
    // R9: above highest index
    blk_read(12, 2, "R9 above range then wrap");
    // R8: latch inputs
    pll_mode_latch = 2'b01; freq_sel_latch = 1'b0; wc(2);
    blk_read(0, 1, "R8 latch mirror");
    // R5: length change
    blk_write(7, 1, '{8'hE3});
    blk_read(5, 2, "R5 read after length change");

    // R11: STOP mid-byte
    bus_start();
    send_byte(addr_of(strap_hi, strap_lo), 0, 0, ak);
    send_byte(8'd1, 0, 0, ak); send_byte(8'd1, 0, 0, ak);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_stop();
    blk_read(1, 1, "R11 STOP abort kept bank");
    // R11: repeated START mid-byte, then a fresh write
    bus_start();
    send_byte(addr_of(strap_hi, strap_lo), 0, 0, ak);
    send_byte(8'd2, 0, 0, ak); send_byte(8'd1, 0, 0, ak);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    blk_write(7, 1, '{8'h05});
    blk_read(1, 2, "R11 START abort kept bank");
    chk(rd_count == 5'd5, "R11 write after restart", rd_count, 5);

    wc(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule